// File: doc/BRIEF.md
# Asymmetric 4-1-1 Decoder Steering

This block sits between a queue of length-decoded instructions and three parallel uop decoders. Each queue entry carries a uop count and a small tag. Every cycle the block decides how many entries leave the queue, which decoder slot each one lands in, and how many uops each slot emits. The slots are not equal. Slot 0 handles an instruction of one to four uops. Slots 1 and 2 handle only single-uop instructions.

An instruction of more than four uops is handed from slot 0 to a counter-driven microcode sequencer. The sequencer then supplies that instruction's uops in chunks of up to four per cycle. All three decoders stay idle until it finishes. When a multi-uop instruction sits in slot 1 or slot 2, that slot and every later slot stay empty. The instruction remains in the queue, so on the next cycle it is the head entry and reaches slot 0.

The downstream uop queue reports its free entries each cycle. A group is issued only when all of its uops fit in that space. Otherwise nothing is taken that cycle.

The control is a two-state machine:
- `ST_DEC`: normal steering.
- `ST_SEQ`: the sequencer is draining.

Its transitions are:
- **handoff**: `ST_DEC` to `ST_SEQ`, when the head entry needs more than four uops.
- **finish**: `ST_SEQ` to `ST_DEC`, in the cycle the last chunk is emitted.
- **hold**: every other cycle, the machine stays in its current state.

Top module: `dsteer_top`

## Requirements
- R1: After reset the block is in `ST_DEC`. `seq_active` is 0, and with no valid entries `consume`, `slot_vld` and `ms_start` are all 0.
- R2: A head entry with uop count 1 to 4 goes to slot 0, and `s0_ucnt` equals that count. `s0_ucnt` is 0 when slot 0 is empty.
- R3: Slot 1 or slot 2 takes its entry only if the entry's uop count is exactly 1. A multi-uop entry there leaves that slot and every later slot empty, and it is not consumed.
- R4: Slots fill in program order. Slot k is valid only when slot k-1 is valid and queue entry k is valid.
- R5: `consume` equals the number of valid slots. In a handoff cycle it is 1.
- R6: When slot 0's count plus one for each other taken slot exceeds `dq_free`, `consume` is 0 and `slot_vld` is 0 in that cycle.
- R7: A head entry with a count above 4 raises `ms_start` with `ms_ucnt` and `ms_tag` of that entry. In that cycle `consume` is 1 and no slot is valid, and on the next cycle `seq_active` is 1.
- R8: While `seq_active` is 1, `seq_cnt` is min(remaining, 4) when that value fits in `dq_free`, and 0 otherwise. Only emitted uops reduce the remaining count.
- R9: `seq_done` is 1 in the cycle of the final chunk. `seq_active` is 0 on the following cycle. While `seq_active` is 1, `consume` and `slot_vld` are 0.
- R10: With counts 4, 1, 1 at the head and at least 6 free entries, all three slots are valid and 6 uops are emitted in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iq_vld | input | 3 | Valid bits of the three head queue entries, contiguous from bit 0 |
| iq_ucnt | input | 12 | Uop count of entry k in bits [4k+3:4k]; legal values 1 to 15 |
| iq_tag | input | 24 | Tag of entry k in bits [8k+7:8k] |
| dq_free | input | 4 | Free entries in the downstream uop queue |
| consume | output | 2 | Entries popped from the instruction queue this cycle |
| slot_vld | output | 3 | Slot k emits this cycle |
| slot_tag | output | 24 | Tag of slot k in bits [8k+7:8k]; zero when the slot is empty |
| s0_ucnt | output | 3 | Uops emitted by slot 0 (0 to 4) |
| ms_start | output | 1 | Handoff of the head entry to the sequencer |
| ms_ucnt | output | 4 | Uop count handed to the sequencer |
| ms_tag | output | 8 | Tag handed to the sequencer |
| seq_active | output | 1 | Sequencer owns the uop path (`ST_SEQ`) |
| seq_cnt | output | 3 | Uops the sequencer emits this cycle |
| seq_done | output | 1 | Final sequencer chunk this cycle |

## Verification
The bench builds the block with its defaults: a 4-bit count, a 4-bit free count, slot 0 limited to 4 uops, and three slots. The 4-bit count allows sequencer handoffs of up to 15 uops. That is long enough for a four-chunk drain ending in a partial chunk. The 4-bit free count lets the free space drop both below a full 4+1+1 group and below a single sequencer chunk, so stalls in both states are within reach.

// File: rtl/dsteer_pkg.sv
package dsteer_pkg;
    typedef enum logic {
        ST_DEC = 1'b0,
        ST_SEQ = 1'b1
    } steer_st_e;
endpackage

// File: rtl/dsteer_gate.sv
// Acceptance gate for a single-uop slot (slots 1 and up).
module dsteer_gate #(
    parameter int CW = 4
) (
    input  logic          prev_take,
    input  logic          ent_vld,
    input  logic [CW-1:0] ent_ucnt,
    output logic          take
);
    // In-order fill: this slot may only follow a taken slot, and only a
    // single-uop instruction fits here.
    assign take = prev_take && ent_vld && (ent_ucnt == CW'(1));
endmodule

// File: rtl/dsteer_useq.sv
// Counter model of the microcode sequencer.
module dsteer_useq #(
    parameter int CW     = 4,
    parameter int FW     = 4,
    parameter int S0_MAX = 4,
    localparam int QW    = $clog2(S0_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_cnt,
    input  logic          active,
    input  logic [FW-1:0] free,
    output logic [QW-1:0] chunk_out,
    output logic          last
);
    localparam logic [CW-1:0] MAXC = CW'(S0_MAX);

    logic [CW-1:0] rem_q;
    logic [CW-1:0] chunk;
    logic          go;

    always_comb begin
        chunk = (rem_q > MAXC) ? MAXC : rem_q;
        go    = active && (32'(chunk) <= 32'(free));
    end

    assign chunk_out = go ? chunk[QW-1:0] : '0;
    assign last      = go && (rem_q <= MAXC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_cnt;
        end else if (go) begin
            rem_q <= rem_q - chunk;
        end
    end

    // R8: an emitted chunk never exceeds the reported free space
    p_seq_fit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_out != '0) |-> (32'(chunk_out) <= 32'(free)));

    // R8: a stalled cycle keeps the remaining count
    p_seq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !load && chunk_out == '0) |=> $stable(rem_q));
endmodule

// File: rtl/dsteer_top.sv
module dsteer_top #(
    parameter int NSLOT  = 3,
    parameter int CW     = 4,
    parameter int TW     = 8,
    parameter int FW     = 4,
    parameter int S0_MAX = 4,
    localparam int QW    = $clog2(S0_MAX + 1),
    localparam int NW    = $clog2(NSLOT + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSLOT-1:0]    iq_vld,
    input  logic [NSLOT*CW-1:0] iq_ucnt,
    input  logic [NSLOT*TW-1:0] iq_tag,
    input  logic [FW-1:0]       dq_free,
    output logic [NW-1:0]       consume,
    output logic [NSLOT-1:0]    slot_vld,
    output logic [NSLOT*TW-1:0] slot_tag,
    output logic [QW-1:0]       s0_ucnt,
    output logic                ms_start,
    output logic [CW-1:0]       ms_ucnt,
    output logic [TW-1:0]       ms_tag,
    output logic                seq_active,
    output logic [QW-1:0]       seq_cnt,
    output logic                seq_done
);
    import dsteer_pkg::*;

    localparam int            TOTW = CW + 1;
    localparam logic [CW-1:0] MAXC = CW'(S0_MAX);

    steer_st_e     state_q, state_d;
    logic [NSLOT-1:0] take;
    logic [CW-1:0] head_cnt;
    logic          in_dec;
    logic          handoff;
    logic          fits;
    logic [TOTW-1:0] total;
    logic          seq_last;

    assign head_cnt = iq_ucnt[CW-1:0];
    assign in_dec   = (state_q == ST_DEC);
    assign handoff  = in_dec && iq_vld[0] && (head_cnt > MAXC);
    assign take[0]  = in_dec && iq_vld[0] && (head_cnt <= MAXC);

    genvar k;
    generate
        for (k = 1; k < NSLOT; k++) begin : g_gate
            dsteer_gate #(.CW(CW)) gate_i (
                .prev_take (take[k-1]),
                .ent_vld   (iq_vld[k]),
                .ent_ucnt  (iq_ucnt[k*CW +: CW]),
                .take      (take[k])
            );
        end
    endgenerate

    always_comb begin
        total = take[0] ? {1'b0, head_cnt} : '0;
        for (int s = 1; s < NSLOT; s++) begin
            total = total + TOTW'(take[s]);
        end
        fits = (32'(total) <= 32'(dq_free));
    end

    dsteer_useq #(.CW(CW), .FW(FW), .S0_MAX(S0_MAX)) useq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (handoff),
        .load_cnt  (head_cnt),
        .active    (state_q == ST_SEQ),
        .free      (dq_free),
        .chunk_out (seq_cnt),
        .last      (seq_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DEC;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d    = state_q;
        slot_vld   = '0;
        consume    = '0;
        ms_start   = 1'b0;
        seq_active = 1'b0;
        seq_done   = 1'b0;
        unique case (state_q)
            ST_DEC: begin
                if (handoff) begin
                    ms_start = 1'b1;
                    consume  = NW'(1);
                    state_d  = ST_SEQ;
                end else if (fits) begin
                    slot_vld = take;
                    consume  = NW'($countones(take));
                end
            end
            ST_SEQ: begin
                seq_active = 1'b1;
                seq_done   = seq_last;
                if (seq_last) begin
                    state_d = ST_DEC;
                end
            end
            default: state_d = ST_DEC;
        endcase
    end

    assign s0_ucnt = slot_vld[0] ? head_cnt[QW-1:0] : '0;
    assign ms_ucnt = ms_start ? head_cnt : '0;
    assign ms_tag  = ms_start ? iq_tag[TW-1:0] : '0;

    generate
        for (k = 0; k < NSLOT; k++) begin : g_tag
            assign slot_tag[k*TW +: TW] = slot_vld[k] ? iq_tag[k*TW +: TW] : '0;
        end
        for (k = 1; k < NSLOT; k++) begin : g_chk
            // R4: a slot is never filled past an empty one
            p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
                slot_vld[k] |-> slot_vld[k-1]);
            // R3: trailing slots carry single-uop instructions only
            p_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
                slot_vld[k] |-> (iq_ucnt[k*CW +: CW] == CW'(1)));
        end
    endgenerate

    // R6: emitted uops fit the downstream space
    p_fit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld != '0) |-> (32'(s0_ucnt) + 32'($countones(slot_vld[NSLOT-1:1]))
                              <= 32'(dq_free)));
    // R7: a handoff enters the sequencer state next cycle
    p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ms_start |=> seq_active);
    // R9: decoders are quiet while the sequencer drains
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_active |-> (consume == '0 && slot_vld == '0 && !ms_start));
    // R9: done returns control to the decoders
    p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_active);
    // R10: peak output is 4 + 1 + 1
    p_peak_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(s0_ucnt) + 32'($countones(slot_vld)) <= 32'(S0_MAX + NSLOT)));
endmodule

// File: tb/dsteer_top_tb.sv
module dsteer_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NPROG      = 320;
    localparam int LIMIT      = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  iq_vld = '0;
    logic [11:0] iq_ucnt = '0;
    logic [23:0] iq_tag = '0;
    logic [3:0]  dq_free = '0;
    logic [1:0]  consume;
    logic [2:0]  slot_vld;
    logic [23:0] slot_tag;
    logic [2:0]  s0_ucnt;
    logic        ms_start;
    logic [3:0]  ms_ucnt;
    logic [7:0]  ms_tag;
    logic        seq_active;
    logic [2:0]  seq_cnt;
    logic        seq_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsteer_top dut_i (
        .clk(clk), .rst_n(rst_n), .iq_vld(iq_vld), .iq_ucnt(iq_ucnt),
        .iq_tag(iq_tag), .dq_free(dq_free), .consume(consume),
        .slot_vld(slot_vld), .slot_tag(slot_tag), .s0_ucnt(s0_ucnt),
        .ms_start(ms_start), .ms_ucnt(ms_ucnt), .ms_tag(ms_tag),
        .seq_active(seq_active), .seq_cnt(seq_cnt), .seq_done(seq_done)
    );

    int prog [NPROG];
    int n_run = 0;
    int n_fail = 0;
    bit reported = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!reported) begin
            reported = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed;
        int head, cyc, rem, in_seq;
        int directed [24] = '{1,1,1, 4,1,1, 2,1,1, 1,3,1, 1,1,2, 7, 1,1, 15, 1, 5, 4,1,1};
        seed = 32'h1234_5678;
        for (int i = 0; i < NPROG; i++) begin
            if (i < 24) prog[i] = directed[i];
            else begin
                seed = seed * 1664525 + 1013904223;
                case ((seed >> 8) % 10)
                    0,1,2,3,4,5: prog[i] = 1;
                    6,7:         prog[i] = 2 + int'((seed >> 16) % 3);
                    default:     prog[i] = 5 + int'((seed >> 16) % 11);
                endcase
            end
        end
        head = 0; cyc = 0; rem = 0; in_seq = 0;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "consume", int'(consume), 0);
        chk("R1", "seq_active", int'(seq_active), 0);
        chk("R1", "slot_vld", int'(slot_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ms_start after reset", int'(ms_start), 0);
        chk("R1", "seq_active after reset", int'(seq_active), 0);

        while ((head < NPROG || in_seq != 0) && cyc < LIMIT) begin
            int n, free, e_cons, e_slots, e_s0, e_start, e_mscnt, e_seq, e_done, e_tot;
            int c [3];
            string rq;
            // drive
            seed = seed * 1664525 + 1013904223;
            if (cyc < 30) free = 15;
            else case ((seed >> 12) % 8)
                0: free = 0;
                1: free = 1;
                2: free = 3;
                3: free = 5;
                default: free = 15;
            endcase
            n = NPROG - head;
            if (n > 3) n = 3;
            for (int k = 0; k < 3; k++) begin
                c[k] = (k < n) ? prog[head + k] : 1;
                iq_vld[k] = (k < n);
                iq_ucnt[k*4 +: 4] = 4'(c[k]);
                iq_tag[k*8 +: 8] = 8'(head + k);
            end
            dq_free = 4'(free);
            // model
            e_cons = 0; e_slots = 0; e_s0 = 0; e_start = 0; e_mscnt = 0;
            e_seq = 0; e_done = 0; e_tot = 0;
            rq = "R5";
            if (in_seq != 0) begin
                int ch;
                ch = (rem > 4) ? 4 : rem;
                if (ch <= free) begin
                    e_seq = ch;
                    e_done = (ch == rem);
                end
            end else if (n > 0) begin
                if (c[0] > 4) begin
                    e_start = 1; e_cons = 1; e_mscnt = c[0];
                end else begin
                    int s1, s2;
                    s1 = (n > 1 && c[1] == 1);
                    s2 = (s1 != 0 && n > 2 && c[2] == 1);
                    e_tot = c[0] + s1 + s2;
                    if (e_tot <= free) begin
                        e_slots = 1 | (s1 << 1) | (s2 << 2);
                        e_cons = 1 + s1 + s2;
                        e_s0 = c[0];
                    end else begin
                        rq = "R6";
                        e_tot = 0;
                    end
                    if (n > 1 && c[1] != 1) rq = (rq == "R6") ? "R6" : "R3";
                end
            end
            #1;
            chk(rq, "consume", int'(consume), e_cons);
            chk((rq == "R5") ? "R4" : rq, "slot_vld", int'(slot_vld), e_slots);
            chk("R2", "s0_ucnt", int'(s0_ucnt), e_s0);
            chk("R7", "ms_start", int'(ms_start), e_start);
            chk("R7", "ms_ucnt", int'(ms_ucnt), e_mscnt);
            if (e_start != 0) chk("R7", "ms_tag", int'(ms_tag), (head & 255));
            if (e_slots != 0) chk("R2", "slot0 tag", int'(slot_tag[7:0]), (head & 255));
            if (e_slots[2]) chk("R4", "slot2 tag", int'(slot_tag[23:16]), ((head + 2) & 255));
            chk("R9", "seq_active", int'(seq_active), in_seq);
            chk("R8", "seq_cnt", int'(seq_cnt), e_seq);
            chk("R9", "seq_done", int'(seq_done), e_done);
            if (e_tot == 6) chk("R10", "uops in 4+1+1 cycle",
                                int'(s0_ucnt) + int'(slot_vld[1]) + int'(slot_vld[2]), 6);
            @(posedge clk);
            head += e_cons;
            if (e_start != 0) begin
                in_seq = 1; rem = e_mscnt;
            end else if (in_seq != 0) begin
                rem -= e_seq;
                if (rem == 0) in_seq = 0;
            end
            cyc++;
            @(negedge clk);
        end
        if (cyc >= LIMIT) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, LIMIT);
        end
        finish_run();
    end
endmodule